// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a small microcontroller. A 16-state controller advances on each rising edge of the test clock under the mode-select input. It is reset asynchronously by an active-low test reset. A 4-bit instruction register chooses which data path sits between serial input and serial output: a 32-bit identification register, a 1-bit bypass register, or an external boundary scan chain. The chain is reached through capture, shift and update strobes and a return serial bit.

The current instruction also drives plain control outputs to the pad ring and the core. These are a pad three-state request, a request that pads take their values from the boundary scan update latches, a functional reset request, and a debug-port enable. The debug-port enable stays set once it has been raised. The serial port has no flow control: one bit moves per test clock, so the block has no valid/ready edge and no back-pressure.

Top module: `scan_tap_top`

## Requirements
- R1: The controller follows the standard 16-state graph on rising `tck_i`, with `tms_i` choosing each branch. Five consecutive `tms_i`=1 clocks reach Test-Logic-Reset from any state, and `trst_n_i`=0 forces that state at once.
- R2: In Capture-IR the instruction shifter loads 4'b0001. Shift-IR shifts toward bit 0, and bit 0 is presented first on `tdo_o`. The shifted code becomes the active instruction on the rising edge that leaves Update-IR.
- R3: After `trst_n_i`=0 or any clock spent in Test-Logic-Reset, the active instruction is IDCODE (4'b0001).
- R4: With IDCODE (4'b0001) active, Capture-DR loads the 32-bit identification value with bit 0 forced to 1. The value is shifted out bit 0 first, so the first bit out is always 1.
- R5: BYPASS (4'b0110) and every unassigned code 4'b0111 to 4'b1111 select the 1-bit bypass register. It captures 0, so data leaves one clock behind its entry. None of these codes raises any pad or reset control.
- R6: HIGHZ (4'b0100) sets `pad_hiz_o` and `func_rst_req_o`, clears `pad_bsr_drive_o`, and selects bypass.
- R7: CLAMP (4'b0101) sets `pad_bsr_drive_o` and `func_rst_req_o`, clears `pad_hiz_o`, and selects bypass.
- R8: EXTEST (4'b0000) sets `pad_bsr_drive_o` and `func_rst_req_o`. It routes the external chain, so `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` pulse in Capture-DR, Shift-DR and Update-DR, and `tdo_o` carries `bsr_so_i`.
- R9: SAMPLE/PRELOAD (4'b0010) routes the external chain exactly as in R8 and leaves all pad and reset controls low.
- R10: Debug enable (4'b0011) selects bypass and raises `dbg_en_o` one clock after it becomes active. `dbg_en_o` then stays high through later instructions and through Test-Logic-Reset entered by `tms_i`. Only `trst_n_i`=0 clears it.
- R11: `tdo_o` and `tdo_oe_o` change on falling `tck_i`. `tdo_oe_o` is 1 only while the controller is in Shift-IR or Shift-DR, and `tdo_o` is 0 otherwise.
- R12: Pause-DR holds the data shifter unchanged, so a shift split by a pause yields the same bits as an unbroken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| trst_n_i | input | 1 | Asynchronous active-low test reset (also tied to power-on reset at chip level) |
| tms_i | input | 1 | Mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling `tck_i` |
| tdo_oe_o | output | 1 | Output enable for `tdo_o` |
| bsr_capture_o | output | 1 | External chain capture strobe |
| bsr_shift_o | output | 1 | External chain shift strobe |
| bsr_update_o | output | 1 | External chain update strobe |
| bsr_so_i | input | 1 | Last bit of the external chain |
| pad_hiz_o | output | 1 | Request to three-state all output pads |
| pad_bsr_drive_o | output | 1 | Pads take values from boundary scan update latches |
| func_rst_req_o | output | 1 | Functional reset request to the core |
| dbg_en_o | output | 1 | Sticky debug-port enable |

## Verification
The hardest state to reach is a debug enable that has to outlive everything except the reset pin. The stimulus loads the debug instruction, then loads a different one, then sends five mode-select highs from Shift-DR to reach Test-Logic-Reset. It then confirms that the identification value is back in the path while `dbg_en_o` is still set. Only after that does it pulse `trst_n_i` and look for the clear. A shift split by Pause-DR is also hard to see from the ports. A full identification read is therefore split by a pause, and the two halves are rejoined and compared against the unbroken value.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_DBG_EN  = 4'b0011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0100;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0101;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b0110;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       trst_n_i,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) state_q <= ST_TLR;
    else           state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  shift_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_q == ST_SH_DR && !tms_i) |=> (state_q == ST_SH_DR));

  // R1
  sel_ir_exit_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_q == ST_SEL_IR && tms_i) |=> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       trst_n_i,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       ir_so_o,
  output dr_path_e   path_o,
  output logic       pad_hiz_o,
  output logic       pad_bsr_o,
  output logic       func_rst_o,
  output logic       dbg_en_o
);

  logic [IR_W-1:0] ir_sr_q;
  logic [IR_W-1:0] ir_q;
  logic            dbg_q;

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      ir_sr_q <= IR_CAPTURE;
    end else if (state_i == ST_CAP_IR) begin
      ir_sr_q <= IR_CAPTURE;
    end else if (state_i == ST_SH_IR) begin
      ir_sr_q <= {tdi_i, ir_sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i)                  ir_q <= OP_IDCODE;
    else if (state_i == ST_TLR)     ir_q <= OP_IDCODE;
    else if (state_i == ST_UPD_IR)  ir_q <= ir_sr_q;
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i)                 dbg_q <= 1'b0;
    else if (ir_q == OP_DBG_EN)    dbg_q <= 1'b1;
  end

  always_comb begin
    unique case (ir_q)
      OP_EXTEST, OP_SAMPLE: path_o = PATH_BSR;
      OP_IDCODE:            path_o = PATH_ID;
      default:              path_o = PATH_BYP;
    endcase
  end

  assign pad_hiz_o  = (ir_q == OP_HIGHZ);
  assign pad_bsr_o  = (ir_q == OP_EXTEST) || (ir_q == OP_CLAMP);
  assign func_rst_o = (ir_q == OP_EXTEST) || (ir_q == OP_CLAMP) || (ir_q == OP_HIGHZ);
  assign dbg_en_o   = dbg_q;
  assign ir_so_o    = ir_sr_q[0];

  // R2
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_IR) |=> (ir_sr_q == IR_CAPTURE));

  // R3
  tlr_idcode_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_TLR) |=> (ir_q == OP_IDCODE));

  // R10
  dbg_sticky_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    dbg_q |=> dbg_q);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int               ID_W    = 32,
  parameter logic [ID_W-1:0]  ID_CODE = 32'h1C0F_A02B
)(
  input  logic       tck_i,
  input  logic       trst_n_i,
  input  tap_state_e state_i,
  input  dr_path_e   path_i,
  input  logic       tdi_i,
  output logic       id_so_o,
  output logic       byp_so_o
);

  localparam logic [ID_W-1:0] ID_LOAD = {ID_CODE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sr_q;
  logic            byp_q;

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      id_sr_q <= ID_LOAD;
    end else if (path_i == PATH_ID) begin
      if (state_i == ST_CAP_DR)     id_sr_q <= ID_LOAD;
      else if (state_i == ST_SH_DR) id_sr_q <= {tdi_i, id_sr_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      byp_q <= 1'b0;
    end else if (path_i == PATH_BYP) begin
      if (state_i == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state_i == ST_SH_DR) byp_q <= tdi_i;
    end
  end

  assign id_so_o  = id_sr_q[0];
  assign byp_so_o = byp_q;

  // R4
  id_lsb_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_DR && path_i == PATH_ID) |=> id_sr_q[0]);

  // R5
  byp_zero_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_DR && path_i == PATH_BYP) |=> !byp_q);

  // R12
  pause_hold_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_PAU_DR) |=> $stable(id_sr_q));

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1C0F_A02B
)(
  input  logic tck_i,
  input  logic trst_n_i,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o,
  input  logic bsr_so_i,
  output logic pad_hiz_o,
  output logic pad_bsr_drive_o,
  output logic func_rst_req_o,
  output logic dbg_en_o
);

  tap_state_e state;
  dr_path_e   path;
  logic       ir_so, id_so, byp_so;
  logic       tdo_d, oe_d;
  logic       bsr_sel;

  tap_fsm u_fsm (
    .tck_i    (tck_i),
    .trst_n_i (trst_n_i),
    .tms_i    (tms_i),
    .state_o  (state)
  );

  tap_ir u_ir (
    .tck_i      (tck_i),
    .trst_n_i   (trst_n_i),
    .state_i    (state),
    .tdi_i      (tdi_i),
    .ir_so_o    (ir_so),
    .path_o     (path),
    .pad_hiz_o  (pad_hiz_o),
    .pad_bsr_o  (pad_bsr_drive_o),
    .func_rst_o (func_rst_req_o),
    .dbg_en_o   (dbg_en_o)
  );

  tap_dr #(.ID_W(ID_W), .ID_CODE(ID_CODE)) u_dr (
    .tck_i    (tck_i),
    .trst_n_i (trst_n_i),
    .state_i  (state),
    .path_i   (path),
    .tdi_i    (tdi_i),
    .id_so_o  (id_so),
    .byp_so_o (byp_so)
  );

  assign bsr_sel       = (path == PATH_BSR);
  assign bsr_capture_o = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift_o   = bsr_sel && (state == ST_SH_DR);
  assign bsr_update_o  = bsr_sel && (state == ST_UPD_DR);

  always_comb begin
    oe_d  = 1'b0;
    tdo_d = 1'b0;
    if (state == ST_SH_IR) begin
      oe_d  = 1'b1;
      tdo_d = ir_so;
    end else if (state == ST_SH_DR) begin
      oe_d = 1'b1;
      unique case (path)
        PATH_ID:  tdo_d = id_so;
        PATH_BSR: tdo_d = bsr_so_i;
        default:  tdo_d = byp_so;
      endcase
    end
  end

  always_ff @(negedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= tdo_d;
      tdo_oe_o <= oe_d;
    end
  end

  // R8
  bsr_strobe_chk: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));

endmodule

// File: tb/scan_tap_top_tb_top.sv
module scan_tap_top_tb_top;

  localparam logic [31:0] ID_PARAM = 32'h1C0F_A02A;
  localparam logic [31:0] ID_EXP   = {ID_PARAM[31:1], 1'b1};

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, bsr_cap, bsr_sh, bsr_upd, bsr_so;
  logic pad_hiz, pad_bsr, func_rst, dbg_en;

  int checks = 0;
  int fails  = 0;

  always #5 tck = ~tck;

  scan_tap_top #(.ID_W(32), .ID_CODE(ID_PARAM)) dut_i (
    .tck_i(tck), .trst_n_i(trst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe),
    .bsr_capture_o(bsr_cap), .bsr_shift_o(bsr_sh), .bsr_update_o(bsr_upd),
    .bsr_so_i(bsr_so),
    .pad_hiz_o(pad_hiz), .pad_bsr_drive_o(pad_bsr),
    .func_rst_req_o(func_rst), .dbg_en_o(dbg_en)
  );

  // external 8-bit chain model
  logic [7:0] bsr_m = 8'h00;
  int bsr_cap_n = 0, bsr_upd_n = 0;
  always @(posedge tck) begin
    if (bsr_cap) begin bsr_m <= 8'h96; bsr_cap_n <= bsr_cap_n + 1; end
    else if (bsr_sh) bsr_m <= {tdi, bsr_m[7:1]};
    if (bsr_upd) bsr_upd_n <= bsr_upd_n + 1;
  end
  assign bsr_so = bsr_m[0];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic tms_v, input logic tdi_v, output logic so, output logic oe);
    @(negedge tck); #1;
    so = tdo; oe = tdo_oe;
    tms = tms_v; tdi = tdi_v;
    @(posedge tck); #2;
  endtask

  task automatic idle(input logic tms_v);
    logic s, o;
    step(tms_v, 1'b0, s, o);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    logic s, o;
    idle(1); idle(1); idle(0); idle(0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], s, o);
      cap[i] = s;
    end
    idle(1); idle(0); idle(0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic s, o;
    dout = '0;
    idle(1); idle(0); idle(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], s, o);
      dout[i] = s;
    end
    idle(1); idle(0);
  endtask

  task automatic do_reset();
    trst_n = 1'b0; tms = 1'b1;
    repeat (3) @(posedge tck);
    #2 trst_n = 1'b1;
    idle(0);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R11 oe idle", {31'b0, tdo_oe}, 32'h0);
    check("R3 ctrl after reset", {28'b0, pad_hiz, pad_bsr, func_rst, dbg_en}, 32'h0);
    shift_dr(32, 32'h0, d);
    check("R4 idcode after reset", d, ID_EXP);
    check("R4 first bit", {31'b0, d[0]}, 32'h1);
  endtask

  task automatic t_ir_capture();
    logic [3:0] c;
    shift_ir(4'b0110, c);
    check("R2 ir capture", {28'b0, c}, 32'h1);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    logic [3:0] c;
    shift_ir(4'b0110, c);
    shift_dr(8, 32'hA5, d);
    check("R5 bypass delay", d, {24'b0, 8'hA5 << 1} & 32'hFF);
    for (int k = 7; k < 16; k++) begin
      shift_ir(4'(k), c);
      shift_dr(8, 32'hC3, d);
      check("R5 reserved code bypass", {20'b0, 4'(k), d[7:0]}, {20'b0, 4'(k), 8'h86});
      check("R5 reserved code ctrl", {29'b0, pad_hiz, pad_bsr, func_rst}, 32'h0);
    end
  endtask

  task automatic t_highz_clamp();
    logic [31:0] d;
    logic [3:0] c;
    shift_ir(4'b0100, c);
    check("R6 highz ctrl", {29'b0, pad_hiz, pad_bsr, func_rst}, 32'b101);
    shift_dr(2, 32'h3, d);
    check("R6 highz bypass", d, 32'h2);
    shift_ir(4'b0101, c);
    check("R7 clamp ctrl", {29'b0, pad_hiz, pad_bsr, func_rst}, 32'b011);
    shift_dr(2, 32'h3, d);
    check("R7 clamp bypass", d, 32'h2);
  endtask

  task automatic t_bsr();
    logic [31:0] d;
    logic [3:0] c;
    int cap0, upd0;
    shift_ir(4'b0000, c);
    check("R8 extest ctrl", {29'b0, pad_hiz, pad_bsr, func_rst}, 32'b011);
    cap0 = bsr_cap_n; upd0 = bsr_upd_n;
    shift_dr(8, 32'h3C, d);
    check("R8 extest chain out", d, 32'h96);
    check("R8 strobes", {cap0 + 1 == bsr_cap_n, upd0 + 1 == bsr_upd_n}, 32'h3);
    check("R8 chain loaded", {24'b0, bsr_m}, 32'h3C);
    shift_ir(4'b0010, c);
    check("R9 sample ctrl", {29'b0, pad_hiz, pad_bsr, func_rst}, 32'h0);
    shift_dr(8, 32'h00, d);
    check("R9 sample chain out", d, 32'h96);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    logic [3:0] c;
    logic s, o;
    shift_ir(4'b0001, c);
    d = '0;
    idle(1); idle(0); idle(0);
    for (int i = 0; i < 16; i++) begin step(i == 15, 1'b0, s, o); d[i] = s; end
    idle(0); idle(0);
    step(1, 1'b0, s, o);
    check("R11 oe low in pause", {31'b0, o}, 32'h0);
    idle(0);
    for (int i = 16; i < 32; i++) begin
      step(i == 31, 1'b0, s, o); d[i] = s;
      if (i == 16) check("R11 oe high in shift", {31'b0, o}, 32'h1);
    end
    idle(1); idle(0);
    check("R12 paused idcode", d, ID_EXP);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    logic [3:0] c;
    shift_ir(4'b0011, c);
    check("R10 dbg set", {31'b0, dbg_en}, 32'h1);
    shift_dr(2, 32'h3, d);
    check("R10 dbg bypass", d, 32'h2);
    shift_ir(4'b0110, c);
    check("R10 dbg held", {31'b0, dbg_en}, 32'h1);
    idle(1); idle(0); idle(0);
    repeat (5) idle(1);
    idle(0);
    check("R10 dbg held after tlr", {31'b0, dbg_en}, 32'h1);
    shift_dr(32, 32'h0, d);
    check("R1 tlr via tms restores idcode", d, ID_EXP);
    do_reset();
    check("R10 dbg cleared by trst", {31'b0, dbg_en}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ir_capture();
    t_bypass();
    t_highz_clamp();
    t_bsr();
    t_pause();
    t_debug();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule